// File: doc/BRIEF.md
# Age-Ordered Issue Queue with Result Wakeup

This block is the scheduling window of a single-issue out-of-order core. The rename stage writes one instruction per cycle into a free slot. Each of its two source operands arrives either as a finished value or as the 4-bit reorder-buffer tag of the result it still needs. Every cycle, two result buses present a valid bit, a tag and a data word. Each pending operand that matches a bus takes that bus data and becomes ready.

From all entries whose two operands are ready, the queue picks the one dispatched earliest and presents it on the issue port. The physical slot it occupies plays no part in the choice. The slot is released at the same clock edge. A flush after a branch misprediction empties the whole queue at one edge. The queue raises `full` when every slot is occupied, and dispatch is refused in that state.

Top module: `issue_queue_age`

## Requirements
- R1: After reset the queue is empty: `full` is 0 and `iss_valid` is 0.
- R2: A dispatched operand with its ready flag set stores the supplied value. An operand with the flag clear stores the tag and waits. An entry whose two operands are ready at the clock edge appears on the issue port from the next cycle, with its opcode, destination tag and both operand values.
- R3: When several entries are ready, the issue port shows the one dispatched earliest, whatever slot it sits in. At most one entry issues per cycle, and `iss_valid` is 1 whenever at least one entry is ready and no flush is asserted.
- R4: A valid broadcast on either bus whose tag equals a waiting operand's tag makes that operand ready, holding that bus's data, from the next cycle. A ready operand keeps its value until its slot is reused.
- R5: `full` is 1 exactly when all 16 slots hold valid entries. A dispatch presented while `full` is 1 is dropped, even if an entry issues in that same cycle.
- R6: When `flush` is 1, every entry is removed at that edge, `iss_valid` is 0 during that cycle, and a dispatch in the same cycle is dropped.
- R7: A dispatched operand marked not ready whose tag matches a valid broadcast in the dispatch cycle is stored as ready, holding the broadcast data.
- R8: An entry shown on the issue port in a cycle without flush is removed at that edge. Its slot is free for a new dispatch from the next cycle.
- R9: The two buses act independently in the same cycle. Operands waiting on the two broadcast tags all wake together. If both buses carry the same tag, bus 0 data is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Misprediction flush; empties the queue |
| disp_valid | input | 1 | A new instruction is presented for dispatch |
| disp_op | input | OP_W | Opcode/control payload of the new instruction |
| disp_dst | input | TAG_W | Reorder-buffer tag of the new instruction's result |
| disp_a_rdy | input | 1 | Operand A value is final |
| disp_a_tag | input | TAG_W | Tag operand A waits on when not ready |
| disp_a_val | input | DATA_W | Operand A value when ready |
| disp_b_rdy | input | 1 | Operand B value is final |
| disp_b_tag | input | TAG_W | Tag operand B waits on when not ready |
| disp_b_val | input | DATA_W | Operand B value when ready |
| wb_valid | input | NBUS | Per-bus broadcast valid |
| wb_tag | input | NBUS*TAG_W | Per-bus result tag, bus k at bits k*TAG_W upward |
| wb_data | input | NBUS*DATA_W | Per-bus result data, bus k at bits k*DATA_W upward |
| full | output | 1 | All slots occupied |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_op | output | OP_W | Opcode of the issued instruction |
| iss_dst | output | TAG_W | Destination tag of the issued instruction |
| iss_a_val | output | DATA_W | Operand A value of the issued instruction |
| iss_b_val | output | DATA_W | Operand B value of the issued instruction |

## Verification
Dispatch and wakeup can fall in the same cycle. The risk is a new entry that misses a broadcast of exactly the tag it waits on. Directed cycles drive a not-ready operand together with a matching broadcast on bus 0 and on bus 1. The check is that the entry issues in the next cycle with the bus data. Issue and dispatch also coincide while the queue is full. A behavioural age-ordered list in the bench predicts, on every clock, which entry issues, what it carries and whether the dispatch is dropped.

// File: rtl/issue_q_pkg.sv
package issue_q_pkg;
   localparam int IQ_DEPTH_DEF  = 16;
   localparam int IQ_TAG_W_DEF  = 4;
   localparam int IQ_DATA_W_DEF = 32;
   localparam int IQ_OP_W_DEF   = 8;
   localparam int IQ_NBUS_DEF   = 2;
   localparam int IQ_NSRC       = 2;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/iq_operand.sv
module iq_operand #(
   parameter int TAG_W  = issue_q_pkg::IQ_TAG_W_DEF,
   parameter int DATA_W = issue_q_pkg::IQ_DATA_W_DEF,
   parameter int NBUS   = issue_q_pkg::IQ_NBUS_DEF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic                   in_rdy,
   input  logic [TAG_W-1:0]       in_tag,
   input  logic [DATA_W-1:0]      in_val,
   input  logic [NBUS-1:0]        bus_valid,
   input  logic [NBUS*TAG_W-1:0]  bus_tag,
   input  logic [NBUS*DATA_W-1:0] bus_data,
   output logic                   rdy,
   output logic [DATA_W-1:0]      val
);
   logic [TAG_W-1:0]  tag_q;
   logic              hit_held, hit_new;
   logic [DATA_W-1:0] data_held, data_new;

   // lowest-numbered bus wins when several match
   always_comb begin
      hit_held  = 1'b0;
      data_held = '0;
      hit_new   = 1'b0;
      data_new  = '0;
      for (int b = NBUS - 1; b >= 0; b--) begin
         if (bus_valid[b] && (bus_tag[b*TAG_W +: TAG_W] == tag_q)) begin
            hit_held  = 1'b1;
            data_held = bus_data[b*DATA_W +: DATA_W];
         end
         if (bus_valid[b] && (bus_tag[b*TAG_W +: TAG_W] == in_tag)) begin
            hit_new  = 1'b1;
            data_new = bus_data[b*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy   <= 1'b0;
         tag_q <= '0;
         val   <= '0;
      end else if (load) begin
         tag_q <= in_tag;
         if (in_rdy) begin
            rdy <= 1'b1;
            val <= in_val;
         end else if (hit_new) begin
            rdy <= 1'b1;
            val <= data_new;
         end else begin
            rdy <= 1'b0;
         end
      end else if (!rdy && hit_held) begin
         rdy <= 1'b1;
         val <= data_held;
      end
   end

   assert_ready_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !load) |=> (rdy && $stable(val)));

   assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !rdy && hit_held) |=> (rdy && val == $past(data_held)));

   assert_wait_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !in_rdy && !hit_new) |=> !rdy);

   assert_same_cycle_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !in_rdy && hit_new) |=> (rdy && val == $past(data_new)));
endmodule

// File: rtl/iq_entry.sv
module iq_entry #(
   parameter int TAG_W  = issue_q_pkg::IQ_TAG_W_DEF,
   parameter int DATA_W = issue_q_pkg::IQ_DATA_W_DEF,
   parameter int OP_W   = issue_q_pkg::IQ_OP_W_DEF,
   parameter int NBUS   = issue_q_pkg::IQ_NBUS_DEF
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     alloc,
   input  logic                                     clear,
   input  logic [OP_W-1:0]                          in_op,
   input  logic [TAG_W-1:0]                         in_dst,
   input  logic [issue_q_pkg::IQ_NSRC-1:0]          in_src_rdy,
   input  logic [issue_q_pkg::IQ_NSRC*TAG_W-1:0]    in_src_tag,
   input  logic [issue_q_pkg::IQ_NSRC*DATA_W-1:0]   in_src_val,
   input  logic [NBUS-1:0]                          bus_valid,
   input  logic [NBUS*TAG_W-1:0]                    bus_tag,
   input  logic [NBUS*DATA_W-1:0]                   bus_data,
   output logic                                     valid,
   output logic                                     req,
   output logic [OP_W-1:0]                          op,
   output logic [TAG_W-1:0]                         dst,
   output logic [issue_q_pkg::IQ_NSRC*DATA_W-1:0]   src_val
);
   localparam int NSRC = issue_q_pkg::IQ_NSRC;

   logic [NSRC-1:0] src_rdy;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      iq_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W), .NBUS(NBUS)) u_opnd (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (alloc),
         .in_rdy    (in_src_rdy[s]),
         .in_tag    (in_src_tag[s*TAG_W +: TAG_W]),
         .in_val    (in_src_val[s*DATA_W +: DATA_W]),
         .bus_valid (bus_valid),
         .bus_tag   (bus_tag),
         .bus_data  (bus_data),
         .rdy       (src_rdy[s]),
         .val       (src_val[s*DATA_W +: DATA_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         op    <= '0;
         dst   <= '0;
      end else if (clear) begin
         valid <= 1'b0;
      end else if (alloc) begin
         valid <= 1'b1;
         op    <= in_op;
         dst   <= in_dst;
      end
   end

   assign req = valid && (&src_rdy);

   assert_freed_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !valid);

   assert_alloc_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && !clear) |=> (valid && dst == $past(in_dst)));

   assert_no_alloc_over_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !valid);
endmodule

// File: rtl/iq_age_matrix.sv
module iq_age_matrix #(
   parameter int DEPTH = issue_q_pkg::IQ_DEPTH_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] alloc_vec,
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] grant
);
   // older_q[i][j] = 1 : slot i was written before slot j
   logic [DEPTH-1:0] older_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < DEPTH; j++) begin
               if (i != j) begin
                  if (alloc_vec[j])      older_q[i][j] <= 1'b1;
                  else if (alloc_vec[i]) older_q[i][j] <= 1'b0;
               end
            end
         end
      end
   end

   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         logic blocked;
         blocked = 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            if (i != j && req[i] && older_q[i][j]) blocked = 1'b1;
         end
         grant[j] = req[j] && !blocked;
      end
   end

   assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_when_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|grant));

   assert_single_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_vec));
endmodule

// File: rtl/issue_queue_age.sv
module issue_queue_age #(
   parameter int DEPTH  = issue_q_pkg::IQ_DEPTH_DEF,
   parameter int TAG_W  = issue_q_pkg::IQ_TAG_W_DEF,
   parameter int DATA_W = issue_q_pkg::IQ_DATA_W_DEF,
   parameter int OP_W   = issue_q_pkg::IQ_OP_W_DEF,
   parameter int NBUS   = issue_q_pkg::IQ_NBUS_DEF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   disp_valid,
   input  logic [OP_W-1:0]        disp_op,
   input  logic [TAG_W-1:0]       disp_dst,
   input  logic                   disp_a_rdy,
   input  logic [TAG_W-1:0]       disp_a_tag,
   input  logic [DATA_W-1:0]      disp_a_val,
   input  logic                   disp_b_rdy,
   input  logic [TAG_W-1:0]       disp_b_tag,
   input  logic [DATA_W-1:0]      disp_b_val,
   input  logic [NBUS-1:0]        wb_valid,
   input  logic [NBUS*TAG_W-1:0]  wb_tag,
   input  logic [NBUS*DATA_W-1:0] wb_data,
   output logic                   full,
   output logic                   iss_valid,
   output logic [OP_W-1:0]        iss_op,
   output logic [TAG_W-1:0]       iss_dst,
   output logic [DATA_W-1:0]      iss_a_val,
   output logic [DATA_W-1:0]      iss_b_val
);
   localparam int NSRC = issue_q_pkg::IQ_NSRC;

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 64) else $error("issue_queue_age: DEPTH out of range");
      assert (TAG_W >= 1)                else $error("issue_queue_age: TAG_W must be positive");
      assert (NBUS >= 1)                 else $error("issue_queue_age: NBUS must be positive");
      assert (DATA_W >= 1 && OP_W >= 1)  else $error("issue_queue_age: widths must be positive");
   end

   logic [DEPTH-1:0]       valid_vec, req_vec, grant_vec, free_pick, alloc_vec;
   logic                   accept;
   logic [OP_W-1:0]        e_op  [DEPTH];
   logic [TAG_W-1:0]       e_dst [DEPTH];
   logic [NSRC*DATA_W-1:0] e_src [DEPTH];

   // lowest-numbered free slot
   always_comb begin
      free_pick = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (!valid_vec[k]) free_pick = DEPTH'(1) << k;
      end
   end

   assign full      = &valid_vec;
   assign accept    = disp_valid && !full && !flush;
   assign alloc_vec = accept ? free_pick : '0;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      iq_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .NBUS(NBUS)) u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc      (alloc_vec[g]),
         .clear      (flush || grant_vec[g]),
         .in_op      (disp_op),
         .in_dst     (disp_dst),
         .in_src_rdy ({disp_b_rdy, disp_a_rdy}),
         .in_src_tag ({disp_b_tag, disp_a_tag}),
         .in_src_val ({disp_b_val, disp_a_val}),
         .bus_valid  (wb_valid),
         .bus_tag    (wb_tag),
         .bus_data   (wb_data),
         .valid      (valid_vec[g]),
         .req        (req_vec[g]),
         .op         (e_op[g]),
         .dst        (e_dst[g]),
         .src_val    (e_src[g])
      );
   end

   iq_age_matrix #(.DEPTH(DEPTH)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_vec (alloc_vec),
      .req       (req_vec),
      .grant     (grant_vec)
   );

   // AND-OR selection of the granted slot
   always_comb begin
      iss_op    = '0;
      iss_dst   = '0;
      iss_a_val = '0;
      iss_b_val = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (grant_vec[k]) begin
            iss_op    = iss_op    | e_op[k];
            iss_dst   = iss_dst   | e_dst[k];
            iss_a_val = iss_a_val | e_src[k][0 +: DATA_W];
            iss_b_val = iss_b_val | e_src[k][DATA_W +: DATA_W];
         end
      end
   end

   assign iss_valid = (|grant_vec) && !flush;

   assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

   assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_vec == '0));

   assert_one_in_per_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ($countones(valid_vec) <= $past($countones(valid_vec)) + 1));

   assert_issue_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !disp_valid) |=> ($countones(valid_vec) == $past($countones(valid_vec)) - 1));
endmodule

// File: tb/issue_queue_age_bench.sv
`timescale 1ns/1ps
module issue_queue_age_bench;
   localparam int TW = 4, DW = 32, OW = 8, NB = 2, NQ = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush;
   logic disp_valid;
   logic [OW-1:0] disp_op;
   logic [TW-1:0] disp_dst, disp_a_tag, disp_b_tag;
   logic disp_a_rdy, disp_b_rdy;
   logic [DW-1:0] disp_a_val, disp_b_val;
   logic [NB-1:0] wb_valid;
   logic [NB*TW-1:0] wb_tag;
   logic [NB*DW-1:0] wb_data;
   logic full, iss_valid;
   logic [OW-1:0] iss_op;
   logic [TW-1:0] iss_dst;
   logic [DW-1:0] iss_a_val, iss_b_val;

   always #4 clk = ~clk;

   issue_queue_age u_issue_queue_age (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
      .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
      .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .full(full), .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
      .iss_a_val(iss_a_val), .iss_b_val(iss_b_val)
   );

   typedef struct {
      logic [OW-1:0] op;
      logic [TW-1:0] dst;
      bit            ardy;
      logic [TW-1:0] atag;
      logic [DW-1:0] aval;
      bit            brdy;
      logic [TW-1:0] btag;
      logic [DW-1:0] bval;
   } ment_t;

   ment_t mq[$];          // oldest first
   int    exp_idx;
   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   function automatic bit bus_hit(input logic [TW-1:0] t, output logic [DW-1:0] d);
      d = '0;
      for (int b = NB - 1; b >= 0; b--) begin
         if (wb_valid[b] && wb_tag[b*TW +: TW] == t) begin
            d = wb_data[b*DW +: DW];
            return_hit_dummy(b);
         end
      end
      for (int b = 0; b < NB; b++)
         if (wb_valid[b] && wb_tag[b*TW +: TW] == t) return 1'b1;
      return 1'b0;
   endfunction

   function automatic void return_hit_dummy(input int b);
      if (b < 0) $display("unreachable");
   endfunction

   function automatic ment_t wake_entry(input ment_t e);
      logic [DW-1:0] d;
      if (!e.ardy && bus_hit(e.atag, d)) begin e.ardy = 1'b1; e.aval = d; end
      if (!e.brdy && bus_hit(e.btag, d)) begin e.brdy = 1'b1; e.bval = d; end
      return e;
   endfunction

   task automatic compare();
      bit ev;
      exp_idx = -1;
      foreach (mq[k]) if (exp_idx < 0 && mq[k].ardy && mq[k].brdy) exp_idx = k;
      ev = !flush && exp_idx >= 0;
      chk("iss_valid", 64'(iss_valid), 64'(ev));
      chk("full", 64'(full), 64'(mq.size() == NQ));
      if (ev && iss_valid) begin
         chk("iss_op",    64'(iss_op),    64'(mq[exp_idx].op));
         chk("iss_dst",   64'(iss_dst),   64'(mq[exp_idx].dst));
         chk("iss_a_val", 64'(iss_a_val), 64'(mq[exp_idx].aval));
         chk("iss_b_val", 64'(iss_b_val), 64'(mq[exp_idx].bval));
      end
   endtask

   task automatic model_edge();
      int    sz;
      ment_t e;
      sz = mq.size();
      if (flush) begin
         mq.delete();
         return;
      end
      if (exp_idx >= 0) mq.delete(exp_idx);
      foreach (mq[k]) mq[k] = wake_entry(mq[k]);
      if (disp_valid && sz < NQ) begin
         e.op = disp_op; e.dst = disp_dst;
         e.ardy = disp_a_rdy; e.atag = disp_a_tag; e.aval = disp_a_val;
         e.brdy = disp_b_rdy; e.btag = disp_b_tag; e.bval = disp_b_val;
         if (!e.ardy) e.aval = '0;
         if (!e.brdy) e.bval = '0;
         mq.push_back(wake_entry(e));
      end
   endtask

   task automatic idle();
      flush = 1'b0; disp_valid = 1'b0; disp_op = '0; disp_dst = '0;
      disp_a_rdy = 1'b0; disp_a_tag = '0; disp_a_val = '0;
      disp_b_rdy = 1'b0; disp_b_tag = '0; disp_b_val = '0;
      wb_valid = '0; wb_tag = '0; wb_data = '0;
   endtask

   task automatic put(input logic [OW-1:0] op, input logic [TW-1:0] dst,
                      input bit ar, input logic [TW-1:0] at, input logic [DW-1:0] av,
                      input bit br, input logic [TW-1:0] bt, input logic [DW-1:0] bv);
      disp_valid = 1'b1; disp_op = op; disp_dst = dst;
      disp_a_rdy = ar; disp_a_tag = at; disp_a_val = av;
      disp_b_rdy = br; disp_b_tag = bt; disp_b_val = bv;
   endtask

   task automatic wb(input int k, input logic [TW-1:0] t, input logic [DW-1:0] d);
      wb_valid[k] = 1'b1;
      wb_tag[k*TW +: TW] = t;
      wb_data[k*DW +: DW] = d;
   endtask

   task automatic cycle();
      #1;
      compare();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      idle();
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cur_req = "R1";
      #1;
      chk("reset full", 64'(full), 64'd0);
      chk("reset iss_valid", 64'(iss_valid), 64'd0);
      cycle();

      // R2 ready operands, back to back
      cur_req = "R2";
      for (int i = 0; i < 3; i++) begin
         put(8'h10 + 8'(i), 4'(i), 1'b1, '0, 32'hA000 + i, 1'b1, '0, 32'hB000 + i);
         cycle();
      end
      repeat (3) cycle();

      // R3 / R9: age beats slot position, two buses at once
      cur_req = "R3";
      for (int i = 0; i < 4; i++) begin
         put(8'h20 + 8'(i), 4'(8 + i), 1'b0, 4'(1 + i), '0, 1'b1, '0, 32'hC0 + i);
         cycle();
      end
      wb(0, 4'd1, 32'h1111);
      cycle();
      put(8'h24, 4'd12, 1'b0, 4'd5, '0, 1'b1, '0, 32'hC4);
      cycle();
      cur_req = "R9";
      wb(0, 4'd5, 32'h5555);
      wb(1, 4'd4, 32'h4444);
      cycle();
      repeat (3) cycle();
      wb(0, 4'd2, 32'h2222);
      wb(1, 4'd3, 32'h3333);
      cycle();
      wb(0, 4'd6, 32'h6060);
      wb(1, 4'd6, 32'h6161);
      cycle();
      repeat (3) cycle();

      // R5 / R8 full behaviour
      cur_req = "R5";
      for (int i = 0; i < NQ; i++) begin
         put(8'h40 + 8'(i), 4'(i), 1'b1, '0, 32'h400 + i, 1'b0, 4'd7, '0);
         cycle();
      end
      #1;
      chk("full after 16", 64'(full), 64'd1);
      put(8'hEE, 4'd15, 1'b1, '0, 32'hDEAD, 1'b1, '0, 32'hBEEF);
      cycle();
      wb(1, 4'd7, 32'h7777);
      put(8'hEF, 4'd15, 1'b1, '0, 32'hDEAD, 1'b1, '0, 32'hBEEF);
      cycle();
      put(8'hF0, 4'd14, 1'b1, '0, 32'hF00, 1'b1, '0, 32'hF01);
      cycle();
      cur_req = "R8";
      for (int i = 0; i < 20; i++) begin
         put(8'h60 + 8'(i), 4'(i), 1'b1, '0, 32'h600 + i, 1'b1, '0, 32'h700 + i);
         cycle();
      end
      repeat (20) cycle();

      // R6 flush
      cur_req = "R6";
      for (int i = 0; i < 5; i++) begin
         put(8'h80 + 8'(i), 4'(i), 1'b0, 4'd9, '0, 1'b1, '0, 32'h80);
         cycle();
      end
      put(8'h85, 4'd5, 1'b1, '0, 32'h1, 1'b1, '0, 32'h2);
      cycle();
      flush = 1'b1;
      put(8'h86, 4'd6, 1'b1, '0, 32'h3, 1'b1, '0, 32'h4);
      cycle();
      #1;
      chk("iss_valid after flush", 64'(iss_valid), 64'd0);
      chk("full after flush", 64'(full), 64'd0);
      wb(0, 4'd9, 32'h9999);
      cycle();
      cycle();

      // R7 dispatch meets broadcast
      cur_req = "R7";
      put(8'h90, 4'd1, 1'b0, 4'd9, '0, 1'b1, '0, 32'h91);
      wb(0, 4'd9, 32'h9A9A);
      cycle();
      put(8'h92, 4'd2, 1'b1, '0, 32'h93, 1'b0, 4'd10, '0);
      wb(1, 4'd10, 32'hA0A0);
      cycle();
      repeat (3) cycle();

      // R4 randomized traffic
      cur_req = "R4";
      for (int n = 0; n < 4000; n++) begin
         if (n == 2000) cur_req = "R3";
         if ($urandom_range(99) < 60)
            put(8'($urandom), 4'($urandom), 1'($urandom_range(1)), 4'($urandom), $urandom,
                1'($urandom_range(1)), 4'($urandom), $urandom);
         if ($urandom_range(99) < 35) wb(0, 4'($urandom), $urandom);
         if ($urandom_range(99) < 35) begin
            logic [TW-1:0] t1;
            t1 = 4'($urandom);
            if (wb_valid[0] && t1 == wb_tag[0 +: TW]) t1 = t1 + 4'd1;
            wb(1, t1, $urandom);
         end
         if ($urandom_range(199) == 0) flush = 1'b1;
         cycle();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule